// File: doc/BRIEF.md
# Paged Local-to-Bus Address Translator

This block sits between a local master, typically a DMA engine that only issues 32-bit local addresses, and a 64-bit system bus. It splits each local address into a page number and an in-page offset. The page number selects an entry in a page table. That entry supplies the upper bits of the bus address, and the offset is copied through unchanged. The result is registered, so a translated address appears exactly one clock after the request.

The table has two build-time variants. In the writable variant, host software loads each entry at run time through a small register port. Each entry is written as two 32-bit words, low then high, and it takes effect only when its high word is written. In the constant variant, every entry is a build-time constant and the write port has no effect. Page size (`PAGE_BITS`, from 12 to 32) and entry count are parameters. Because the local window is 32 bits wide, the entry count times the page size may not exceed 2^32. The constant variant allows at most 16 entries and the writable variant at most 512. Elaboration stops on any parameter set that breaks one of these limits.

A request that lands on an unloaded entry, or on a page number at or beyond the configured entry count, produces no address and raises an error flag instead.

Top module: `paged_xlat`

## Requirements
- R1: When a translation succeeds, `out_addr` carries bits 63..PAGE_BITS of the selected entry's base, and bits PAGE_BITS-1..0 are equal to the same bits of the request address. The selected entry is `req_addr >> PAGE_BITS`.
- R2: The result appears in the clock after `req_valid` is high. `out_valid` and `out_err` are both low in every cycle that does not follow a request. `out_addr` is zero whenever `out_valid` is low.
- R3: After reset, every writable entry is unloaded and both `out_valid` and `out_err` are low.
- R4: A write with `wr_hi`=0 stores `wr_data` in a staging word and does not change any translation. A write with `wr_hi`=1 loads entry `wr_idx` with base {`wr_data`, staging word} and marks the entry loaded.
- R5: Bits of a loaded or constant base below PAGE_BITS are ignored and never reach `out_addr`.
- R6: A request to an unloaded entry gives `out_err`=1 and `out_valid`=0 one clock later.
- R7: A request whose page number is NUM_PAGES or more gives `out_err`=1 and `out_valid`=0 one clock later.
- R8: If an entry is written and looked up in the same cycle, the lookup returns the base the entry held before that write.
- R9: With `FIXED_MODE`=1, entry i is bits 64*i+63..64*i of `FIXED_BASES`, and every entry below NUM_PAGES is loaded from reset. The write port has no effect on translations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | 32 | Local address to translate |
| wr_en | input | 1 | Table write strobe |
| wr_hi | input | 1 | 0: stage low word, 1: commit high word to entry |
| wr_idx | input | max(1,clog2(NUM_PAGES)) | Entry selected by a high-word write |
| wr_data | input | 32 | Write data word |
| out_valid | output | 1 | Translated address valid |
| out_addr | output | 64 | Translated bus address, zero when not valid |
| out_err | output | 1 | Request hit an unloaded or out-of-range entry |

## Verification
The bench sweeps every page number of a small writable table, plus page numbers just above it, using offsets that include the page's first and last byte. A design that lets the page number wrap into the table would return an address where an error is due. A design that mixes base and offset at the page boundary would corrupt the low bits. Low-word-only writes and a write in the same cycle as a lookup are aimed at commit timing: a design that updates on the low word, or that bypasses write data into the lookup, would show a new base one access too early. A constant table with garbage below the page boundary in its bases, and writes aimed at it, catches designs that leak those bits or that let the write port through.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int LADDR_W       = 32;
  localparam int BADDR_W       = 64;
  localparam int MIN_PAGE_BITS = 12;
  localparam int MAX_FIXED     = 16;
  localparam int MAX_DYNAMIC   = 512;

  // width of an entry index, never below one bit
  function automatic int idx_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/xlat_rst_sync.sv
module xlat_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/xlat_table.sv
module xlat_table #(
  parameter int PAGE_BITS = 12,
  parameter int NUM_PAGES = 512,
  parameter bit FIXED_MODE = 1'b0,
  parameter logic [xlat_pkg::MAX_FIXED*64-1:0] FIXED_BASES = '0,
  localparam int IDX_W  = xlat_pkg::idx_w(NUM_PAGES),
  localparam int BASE_W = xlat_pkg::BADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_hi,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [31:0]       wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BASE_W-1:0] rd_base,
  output logic              rd_vld
);
  logic rd_in_range;
  assign rd_in_range = (32'(rd_idx) < 32'(NUM_PAGES));

  if (FIXED_MODE) begin : g_fixed
    logic [BASE_W-1:0] const_tab [NUM_PAGES];
    logic              unused_wr;

    for (genvar i = 0; i < NUM_PAGES; i++) begin : g_ent
      localparam logic [63:0] ENT = FIXED_BASES[64*i +: 64];
      assign const_tab[i] = ENT[63:PAGE_BITS];
    end

    assign unused_wr = ^{wr_en, wr_hi, wr_idx, wr_data, clk, rst_n};
    assign rd_base   = rd_in_range ? const_tab[rd_idx] : '0;
    assign rd_vld    = rd_in_range;
  end else begin : g_dyn
    logic [31:0]          stage_q;
    logic                 stage_en;
    logic                 commit;
    logic [63:0]          new_full;
    logic [BASE_W-1:0]    new_base;
    logic [NUM_PAGES-1:0] ent_we;
    logic [NUM_PAGES-1:0] vld_q, vld_d;
    logic [BASE_W-1:0]    ent_q [NUM_PAGES];

    assign stage_en = wr_en & ~wr_hi;
    assign commit   = wr_en & wr_hi & (32'(wr_idx) < 32'(NUM_PAGES));
    assign new_full = {wr_data, stage_q};
    assign new_base = new_full[63:PAGE_BITS];

    always_comb begin
      for (int i = 0; i < NUM_PAGES; i++) begin
        ent_we[i] = commit && (32'(wr_idx) == i);
      end
      vld_d = vld_q | ent_we;
    end

    // staging word: enable only, no reset needed
    always_ff @(posedge clk) begin
      if (stage_en) stage_q <= wr_data;
    end

    always_ff @(posedge clk) begin
      for (int i = 0; i < NUM_PAGES; i++) begin
        if (ent_we[i]) ent_q[i] <= new_base;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else        vld_q <= vld_d;
    end

    assign rd_base = rd_in_range ? ent_q[rd_idx] : '0;
    assign rd_vld  = rd_in_range && vld_q[rd_idx];

    // R3
    vld_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(vld_q) & ~vld_q) == '0));

    // R4
    stage_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_hi) |=> (vld_q == $past(vld_q)));

    for (genvar i = 0; i < NUM_PAGES; i++) begin : g_chk
      // R4
      commit_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ent_we[i] |=> (vld_q[i] && ent_q[i] == $past(new_base)));
    end
  end
endmodule

// File: rtl/xlat_lookup.sv
module xlat_lookup #(
  parameter int PAGE_BITS = 12,
  parameter int NUM_PAGES = 512,
  localparam int IDX_W  = xlat_pkg::idx_w(NUM_PAGES),
  localparam int BASE_W = xlat_pkg::BADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [BASE_W-1:0] rd_base,
  input  logic              rd_vld,
  output logic              out_valid,
  output logic [63:0]       out_addr,
  output logic              out_err
);
  logic [32:0] page_num;
  logic        in_range;
  logic        hit;
  logic        valid_d, err_d;
  logic [63:0] addr_d;
  logic        valid_q, err_q;
  logic [63:0] addr_q;

  assign page_num = {1'b0, req_addr} >> PAGE_BITS;
  assign in_range = page_num < 33'(NUM_PAGES);
  assign rd_idx   = page_num[IDX_W-1:0];

  always_comb begin
    hit     = req_valid && in_range && rd_vld;
    valid_d = hit;
    err_d   = req_valid && !hit;
    addr_d  = hit ? {rd_base, req_addr[PAGE_BITS-1:0]} : 64'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      addr_q  <= 64'd0;
    end else begin
      valid_q <= valid_d;
      err_q   <= err_d;
      addr_q  <= addr_d;
    end
  end

  assign out_valid = valid_q;
  assign out_err   = err_q;
  assign out_addr  = addr_q;

  // R2
  result_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_valid != out_err));
  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!out_valid && !out_err));
  // R2
  addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_addr == 64'd0));
  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_addr[PAGE_BITS-1:0] == $past(req_addr[PAGE_BITS-1:0])));
  // R7
  range_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !in_range) |=> (out_err && !out_valid));
endmodule

// File: rtl/paged_xlat.sv
module paged_xlat #(
  parameter int PAGE_BITS = 12,
  parameter int NUM_PAGES = 512,
  parameter bit FIXED_MODE = 1'b0,
  parameter logic [xlat_pkg::MAX_FIXED*64-1:0] FIXED_BASES = '0
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 req_valid,
  input  logic [31:0]                          req_addr,
  input  logic                                 wr_en,
  input  logic                                 wr_hi,
  input  logic [xlat_pkg::idx_w(NUM_PAGES)-1:0] wr_idx,
  input  logic [31:0]                          wr_data,
  output logic                                 out_valid,
  output logic [63:0]                          out_addr,
  output logic                                 out_err
);
  localparam int IDX_W  = xlat_pkg::idx_w(NUM_PAGES);
  localparam int BASE_W = xlat_pkg::BADDR_W - PAGE_BITS;

  // parameter legality: the pages must fit inside the 32-bit local window
  if (PAGE_BITS < xlat_pkg::MIN_PAGE_BITS || PAGE_BITS > xlat_pkg::LADDR_W) begin : g_bad_page
    $error("paged_xlat: PAGE_BITS must lie in 12..32");
  end
  if (NUM_PAGES < 1) begin : g_bad_zero
    $error("paged_xlat: NUM_PAGES must be at least 1");
  end
  if (FIXED_MODE && NUM_PAGES > xlat_pkg::MAX_FIXED) begin : g_bad_fixed
    $error("paged_xlat: constant table limited to 16 entries");
  end
  if (!FIXED_MODE && NUM_PAGES > xlat_pkg::MAX_DYNAMIC) begin : g_bad_dyn
    $error("paged_xlat: writable table limited to 512 entries");
  end
  if ((64'(NUM_PAGES) << PAGE_BITS) > 64'h1_0000_0000) begin : g_bad_window
    $error("paged_xlat: NUM_PAGES * 2**PAGE_BITS exceeds the 32-bit window");
  end

  logic              srst_n;
  logic [IDX_W-1:0]  rd_idx;
  logic [BASE_W-1:0] rd_base;
  logic              rd_vld;

  xlat_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  xlat_table #(
    .PAGE_BITS   (PAGE_BITS),
    .NUM_PAGES   (NUM_PAGES),
    .FIXED_MODE  (FIXED_MODE),
    .FIXED_BASES (FIXED_BASES)
  ) u_table (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (wr_en),
    .wr_hi   (wr_hi),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_base (rd_base),
    .rd_vld  (rd_vld)
  );

  xlat_lookup #(
    .PAGE_BITS (PAGE_BITS),
    .NUM_PAGES (NUM_PAGES)
  ) u_lookup (
    .clk       (clk),
    .rst_n     (srst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rd_idx    (rd_idx),
    .rd_base   (rd_base),
    .rd_vld    (rd_vld),
    .out_valid (out_valid),
    .out_addr  (out_addr),
    .out_err   (out_err)
  );

  // R6
  never_both_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !(out_valid && out_err));
endmodule

// File: tb/paged_xlat_test.sv
module paged_xlat_test;
  localparam int DP = 12;   // writable instance page bits
  localparam int DN = 8;    // writable instance entries
  localparam int FP = 28;   // constant instance page bits
  localparam int FN = 12;   // constant instance entries

  function automatic logic [63:0] fbase(input int i);
    return 64'h0000_0F00_0000_0000 + (64'(i) << 36) + 64'(i) * 64'h1000_0000 + 64'hABC;
  endfunction

  function automatic logic [16*64-1:0] build_fb();
    logic [16*64-1:0] v;
    v = '0;
    for (int i = 0; i < 16; i++) v[64*i +: 64] = fbase(i);
    return v;
  endfunction

  localparam logic [16*64-1:0] FB = build_fb();

  logic clk, rst_n;
  logic d_req, d_wr, d_hi; logic [31:0] d_addr, d_wdata; logic [2:0] d_widx;
  logic d_ov, d_oe; logic [63:0] d_oa;
  logic f_req, f_wr, f_hi; logic [31:0] f_addr, f_wdata; logic [3:0] f_widx;
  logic f_ov, f_oe; logic [63:0] f_oa;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [63:0] mbase [DN];
  bit          mval  [DN];
  logic [31:0] mstage;

  paged_xlat #(.PAGE_BITS(DP), .NUM_PAGES(DN), .FIXED_MODE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(d_req), .req_addr(d_addr),
    .wr_en(d_wr), .wr_hi(d_hi), .wr_idx(d_widx), .wr_data(d_wdata),
    .out_valid(d_ov), .out_addr(d_oa), .out_err(d_oe));

  paged_xlat #(.PAGE_BITS(FP), .NUM_PAGES(FN), .FIXED_MODE(1'b1), .FIXED_BASES(FB)) uut_fixed (
    .clk(clk), .rst_n(rst_n), .req_valid(f_req), .req_addr(f_addr),
    .wr_en(f_wr), .wr_hi(f_hi), .wr_idx(f_widx), .wr_data(f_wdata),
    .out_valid(f_ov), .out_addr(f_oa), .out_err(f_oe));

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // expected result of one request to the writable instance
  task automatic d_expect(input logic [31:0] a, output bit ev, output logic [63:0] ea);
    int idx;
    idx = int'(a >> DP);
    ev = (idx < DN) && mval[idx];
    ea = ev ? {mbase[idx][63:DP], a[DP-1:0]} : 64'd0;
  endtask

  task automatic d_xlat(input logic [31:0] a, input string req);
    bit ev; logic [63:0] ea;
    d_expect(a, ev, ea);
    @(negedge clk); d_req = 1'b1; d_addr = a;
    @(negedge clk); d_req = 1'b0;
    chk(d_ov == ev && d_oe == !ev, req, {62'd0, d_ov, d_oe}, {62'd0, ev, !ev});
    chk(d_oa == ea, req, d_oa, ea);
  endtask

  task automatic d_write(input bit hi, input int idx, input logic [31:0] data);
    @(negedge clk); d_wr = 1'b1; d_hi = hi; d_widx = 3'(idx); d_wdata = data;
    @(negedge clk); d_wr = 1'b0;
    if (!hi) mstage = data;
    else begin mbase[idx] = {data, mstage}; mval[idx] = 1; end
  endtask

  task automatic f_xlat(input logic [31:0] a, input string req);
    int idx; bit ev; logic [63:0] ea;
    idx = int'(a >> FP);
    ev = idx < FN;
    ea = ev ? {fbase(idx)[63:FP], a[FP-1:0]} : 64'd0;
    @(negedge clk); f_req = 1'b1; f_addr = a;
    @(negedge clk); f_req = 1'b0;
    chk(f_ov == ev && f_oe == !ev, req, {62'd0, f_ov, f_oe}, {62'd0, ev, !ev});
    chk(f_oa == ea, req, f_oa, ea);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] offs [3];
    offs[0] = 32'h0; offs[1] = 32'hFFF; offs[2] = 32'h7A3;
    rst_n = 1'b0;
    d_req = 0; d_wr = 0; d_hi = 0; d_addr = 0; d_wdata = 0; d_widx = 0;
    f_req = 0; f_wr = 0; f_hi = 0; f_addr = 0; f_wdata = 0; f_widx = 0;
    mstage = 0;
    for (int i = 0; i < DN; i++) begin mval[i] = 0; mbase[i] = 0; end
    repeat (3) @(negedge clk);
    // R3: outputs quiet in reset
    chk(!d_ov && !d_oe && !f_ov && !f_oe, "R3 reset outputs", {60'd0, d_ov, d_oe, f_ov, f_oe}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!d_ov && !d_oe && d_oa == 0, "R3 after reset", d_oa, 64'd0);

    // R3 R6 R7: nothing loaded, everything errors (indices past 7 are out of range)
    for (int i = 0; i < DN + 2; i++) d_xlat((32'(i) << DP) | 32'h123, "R6/R7 unloaded sweep R3");

    // R4 R5: load every entry; low words carry junk below the page boundary
    for (int i = 0; i < DN; i++) begin
      d_write(1'b0, i, (32'(i) * 32'h1111_1000) | 32'h5A5);
      d_write(1'b1, i, 32'h00AB_0000 + 32'(i));
    end

    // R1 R7: full sweep with page-edge offsets
    for (int i = 0; i < DN + 3; i++)
      for (int k = 0; k < 3; k++)
        d_xlat((32'(i) << DP) | offs[k], "R1 sweep R5 R7");
    d_xlat(32'hFFFF_FFFF, "R7 top of window");

    // R2: result only in the cycle after the request
    @(negedge clk); d_req = 1'b1; d_addr = 32'h0000_3456;
    @(negedge clk); d_req = 1'b0;
    chk(d_ov == 1'b1, "R2 result cycle", {63'd0, d_ov}, 64'd1);
    @(negedge clk);
    chk(!d_ov && !d_oe && d_oa == 0, "R2 idle after result", d_oa, 64'd0);

    // R4: low word alone leaves entry 2 unchanged; high word commits
    d_write(1'b0, 2, 32'hCAFE_F000);
    mbase[2] = mbase[2];
    begin
      // the model already staged the low word; entry 2 still holds its old base
      d_xlat(32'h0000_2ABC, "R4 low word alone");
    end
    d_write(1'b1, 2, 32'h1357_2468);
    d_xlat(32'h0000_2ABC, "R4 high word commit");

    // R8: write and lookup of entry 3 in the same cycle
    d_write(1'b0, 3, 32'h7777_7000);
    begin
      bit ev; logic [63:0] ea;
      d_expect(32'h0000_3111, ev, ea);
      @(negedge clk);
      d_wr = 1'b1; d_hi = 1'b1; d_widx = 3'd3; d_wdata = 32'h0BAD_0003;
      d_req = 1'b1; d_addr = 32'h0000_3111;
      @(negedge clk);
      d_wr = 1'b0; d_req = 1'b0;
      chk(d_ov && d_oa == ea, "R8 same-cycle returns old", d_oa, ea);
      mbase[3] = {32'h0BAD_0003, mstage}; mval[3] = 1;
    end
    d_xlat(32'h0000_3111, "R8 new base afterwards");

    // R5: all-ones low word must not leak into the offset bits
    d_write(1'b0, 5, 32'hFFFF_FFFF);
    d_write(1'b1, 5, 32'h0000_0042);
    d_xlat(32'h0000_5000, "R5 low base bits ignored");
    d_xlat(32'h0000_5FFF, "R5 low base bits ignored");

    // R9: constant table sweep, then writes that must not matter
    for (int i = 0; i < 16; i++) begin
      f_xlat((32'(i) << FP) | 32'h0ABC_DEF1, "R9 constant sweep R7");
      f_xlat((32'(i) << FP), "R9 constant sweep R5");
    end
    for (int i = 0; i < FN; i++) begin
      @(negedge clk); f_wr = 1'b1; f_hi = 1'b0; f_widx = 4'(i); f_wdata = 32'hDEAD_BEEF;
      @(negedge clk); f_hi = 1'b1; f_wdata = 32'h5555_5555;
      @(negedge clk); f_wr = 1'b0;
    end
    for (int i = 0; i < FN; i++) f_xlat((32'(i) << FP) | 32'h0FFF_FFFF, "R9 writes ignored");

    summary();
  end
endmodule